// File: doc/BRIEF.md
# Multi-port GPIO pin control bank

This block is a memory-mapped general-purpose I/O controller that sits between a simple 32-bit register bus and a pad ring. It holds up to seven ports of eight pins each. For every pin, software chooses one of four drive modes, sets the value to be driven, and chooses whether the pad's pull-up resistor is active. Software can also read back the level seen on each pad. The block turns each pin's mode and data bit into the three pad controls: output enable, output level and pull-up enable.

A global control word at address zero reports two read-only values: the build's version and the number of eight-pin cores, so the pin count is eight times that number. The same word also holds two writable enable bits, which leave the block as plain outputs. Each port occupies a fixed window of 0x30 bytes, and port p starts at p × 0x30. Pad levels pass through a two-stage synchronizer before software can see them. Interrupt generation, pin multiplexing and the analog pad behaviour are handled by other blocks.

Top module: `pinbank_ctrl`

## Requirements
- R1: Port p's registers sit at byte address p×0x30 plus a fixed offset. The offsets are: input levels at 0x04, output data at 0x08, pin modes at 0x0C and pull-up disables at 0x10. A read puts the addressed register on `bus_rdata` on the clock edge that samples the access, and unused upper bits read 0. The data, input and pull registers are 8 bits wide (bit n is pin n), and the mode register is 16 bits wide.
- R2: In the mode register, pin n's code occupies bits [2n+1:2n]. The codes are 0 input, 1 push-pull, 2 open-drain and 3 open-source. A write updates the pad controls from the next clock edge.
- R3: A pin in input mode (code 0) never has its output enable asserted, and its output level is 0.
- R4: A pin in push-pull mode (code 1) always has its output enable asserted, and its output level equals its data bit.
- R5: A pin in open-drain mode (code 2) has its output level at 0, and its output enable is asserted only while its data bit is 0.
- R6: A pin in open-source mode (code 3) has its output level at 1, and its output enable is asserted only while its data bit is 1.
- R7: A 1 in bit n of the pull register turns pin n's pull-up off (`pad_pull_en` low). A 0 in that bit leaves the pull-up on.
- R8: The control word at address 0x000 reads as follows: bits 15:9 hold the core count (`NUM_PORTS`), bits 8:2 hold `VERSION`, bit 1 is the sync-select enable and bit 0 is the clock-request enable. Only bits 1:0 are writable, and they drive `ctrl_sync_sel` and `ctrl_clk_req`.
- R9: A pad level reaches the input register after two clock edges. Writes to the input register are ignored.
- R10: After reset, every pin is in input mode, every data bit is 0, every pull-up is on, and the control word's enable bits are 0.
- R11: Reads from unused offsets within a window, from the 0x00 slot of ports other than port 0, and from addresses beyond the last port return 0. Writes to any of these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PORTS*8 | Pad levels, asynchronous |
| pad_oe | output | NUM_PORTS*8 | Per-pin output enable |
| pad_out | output | NUM_PORTS*8 | Per-pin output level |
| pad_pull_en | output | NUM_PORTS*8 | Per-pin pull-up enable |
| ctrl_clk_req | output | 1 | Clock-request enable bit |
| ctrl_sync_sel | output | 1 | Sync-select enable bit |

## Verification
Register writes and pad controls take effect on the edge that samples the write strobe. The bench therefore drives each access just after a falling edge and reads the pad outputs at the following falling edge. Read data is registered on the sampling edge, so each read result is taken half a cycle after that edge. A pad change needs two edges before a read can capture it. The bench changes a pad, reads back-to-back, and expects the old value from the reads sampled on the first two edges and the new value from the third read.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int BUS_W         = 32;
  localparam int MODE_W        = 2 * PINS_PER_PORT;

  localparam int OFF_IN   = 'h04;
  localparam int OFF_DOUT = 'h08;
  localparam int OFF_MODE = 'h0C;
  localparam int OFF_PDIS = 'h10;

  typedef enum logic [1:0] {
    DM_INPUT       = 2'd0,
    DM_PUSH_PULL   = 2'd1,
    DM_OPEN_DRAIN  = 2'd2,
    DM_OPEN_SOURCE = 2'd3
  } drive_mode_e;
endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode #(
  parameter int NUM_PORTS   = 7,
  parameter int PORT_STRIDE = 48,
  parameter int ADDR_W      = 9,
  parameter int OFF_W       = 6
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 ctrl_hit,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic [OFF_W-1:0]     port_off
);
  int addr_i;

  always_comb begin
    addr_i   = int'(addr);
    port_hit = '0;
    port_off = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i >= p * PORT_STRIDE && addr_i < (p + 1) * PORT_STRIDE) begin
        port_hit[p] = 1'b1;
        port_off    = OFF_W'(addr_i - p * PORT_STRIDE);
      end
    end
    ctrl_hit = (addr == '0);
  end
endmodule

// File: rtl/pinbank_pad.sv
module pinbank_pad
  import pinbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dout,
  output logic       oe,
  output logic       out
);
  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    case (drive_mode_e'(mode))
      DM_PUSH_PULL: begin
        oe  = 1'b1;
        out = dout;
      end
      DM_OPEN_DRAIN: begin
        oe  = ~dout;
        out = 1'b0;
      end
      DM_OPEN_SOURCE: begin
        oe  = dout;
        out = 1'b1;
      end
      default: begin
        oe  = 1'b0;
        out = 1'b0;
      end
    endcase
  end

  p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (!oe && !out));
  p_push_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (oe && (out == dout)));
  p_open_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!out && (oe != dout)));
  p_open_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (out && (oe == dout)));
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_wr,
  input  logic [OFF_W-1:0]         acc_off,
  input  logic [MODE_W-1:0]        acc_wdata,
  input  logic [PINS_PER_PORT-1:0] pad_in,
  output logic [BUS_W-1:0]         rd_word,
  output logic [PINS_PER_PORT-1:0] pad_oe,
  output logic [PINS_PER_PORT-1:0] pad_out,
  output logic [PINS_PER_PORT-1:0] pad_pull_en
);
  localparam logic [OFF_W-1:0] O_IN   = OFF_W'(OFF_IN);
  localparam logic [OFF_W-1:0] O_DOUT = OFF_W'(OFF_DOUT);
  localparam logic [OFF_W-1:0] O_MODE = OFF_W'(OFF_MODE);
  localparam logic [OFF_W-1:0] O_PDIS = OFF_W'(OFF_PDIS);

  logic [PINS_PER_PORT-1:0] dout_q, dout_nxt;
  logic [PINS_PER_PORT-1:0] pdis_q, pdis_nxt;
  logic [MODE_W-1:0]        mode_q, mode_nxt;
  logic [PINS_PER_PORT-1:0] in_meta_q, in_sync_q;
  logic                     dout_en, pdis_en, mode_en;

  // next state and clock enables
  always_comb begin
    dout_en  = acc_wr && (acc_off == O_DOUT);
    pdis_en  = acc_wr && (acc_off == O_PDIS);
    mode_en  = acc_wr && (acc_off == O_MODE);
    dout_nxt = acc_wdata[PINS_PER_PORT-1:0];
    pdis_nxt = acc_wdata[PINS_PER_PORT-1:0];
    mode_nxt = acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      pdis_q <= '0;
      mode_q <= '0;
    end else begin
      if (dout_en) dout_q <= dout_nxt;
      if (pdis_en) pdis_q <= pdis_nxt;
      if (mode_en) mode_q <= mode_nxt;
    end
  end

  // two-stage input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_meta_q <= '0;
      in_sync_q <= '0;
    end else begin
      in_meta_q <= pad_in;
      in_sync_q <= in_meta_q;
    end
  end

  always_comb begin
    case (acc_off)
      O_IN:    rd_word = BUS_W'(in_sync_q);
      O_DOUT:  rd_word = BUS_W'(dout_q);
      O_MODE:  rd_word = BUS_W'(mode_q);
      O_PDIS:  rd_word = BUS_W'(pdis_q);
      default: rd_word = '0;
    endcase
  end

  assign pad_pull_en = ~pdis_q;

  for (genvar n = 0; n < PINS_PER_PORT; n++) begin : g_pin
    pinbank_pad u_pad (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (mode_q[2*n +: 2]),
      .dout (dout_q[n]),
      .oe   (pad_oe[n]),
      .out  (pad_out[n])
    );
  end

  p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ($stable(dout_q) && $stable(mode_q) && $stable(pdis_q)));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int         NUM_PORTS   = 7,
  parameter int         PORT_STRIDE = 48,
  parameter int         ADDR_W      = 9,
  parameter logic [6:0] VERSION     = 7'd3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_sel,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [BUS_W-1:0]                   bus_wdata,
  output logic [BUS_W-1:0]                   bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pad_pull_en,
  output logic                               ctrl_clk_req,
  output logic                               ctrl_sync_sel
);
  localparam int OFF_W = $clog2(PORT_STRIDE);

  logic                              rst_sync_n;
  logic                              ctrl_hit;
  logic [NUM_PORTS-1:0]              port_hit;
  logic [OFF_W-1:0]                  port_off;
  logic [NUM_PORTS-1:0][BUS_W-1:0]   port_rd;
  logic [1:0]                        ctrl_q, ctrl_nxt;
  logic                              ctrl_en;
  logic [BUS_W-1:0]                  ctrl_word;
  logic [BUS_W-1:0]                  rdata_q, rdata_nxt;
  logic                              rd_en;
  logic                              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:MODE_W];

  pinbank_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  pinbank_decode #(
    .NUM_PORTS  (NUM_PORTS),
    .PORT_STRIDE(PORT_STRIDE),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W)
  ) u_dec (
    .addr    (bus_addr),
    .ctrl_hit(ctrl_hit),
    .port_hit(port_hit),
    .port_off(port_off)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pinbank_port #(.OFF_W(OFF_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .acc_wr     (bus_sel && bus_wr && port_hit[p]),
      .acc_off    (port_off),
      .acc_wdata  (bus_wdata[MODE_W-1:0]),
      .pad_in     (pad_in[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .rd_word    (port_rd[p]),
      .pad_oe     (pad_oe[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_out    (pad_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .pad_pull_en(pad_pull_en[p*PINS_PER_PORT +: PINS_PER_PORT])
    );
  end

  // control word
  always_comb begin
    ctrl_en   = bus_sel && bus_wr && ctrl_hit;
    ctrl_nxt  = bus_wdata[1:0];
    ctrl_word = {16'h0000, 7'(NUM_PORTS), VERSION, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_nxt;
  end

  assign ctrl_sync_sel = ctrl_q[1];
  assign ctrl_clk_req  = ctrl_q[0];

  // read path
  always_comb begin
    rd_en     = bus_sel && !bus_wr;
    rdata_nxt = '0;
    if (ctrl_hit) begin
      rdata_nxt = ctrl_word;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (port_hit[p]) rdata_nxt = port_rd[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

  p_unmapped_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && !ctrl_hit && (port_hit == '0)) |=> (bus_rdata == '0));
  p_ctrl_identity_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && ctrl_hit) |=>
      ((bus_rdata[15:9] == 7'(NUM_PORTS)) && (bus_rdata[8:2] == VERSION) &&
       (bus_rdata[31:16] == '0)));
  p_ctrl_pins_follow_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_sel && bus_wr && ctrl_hit) |=> ($stable(ctrl_clk_req) && $stable(ctrl_sync_sel)));
endmodule

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
  localparam int NP   = 7;
  localparam int NPIN = NP * 8;
  localparam logic [6:0] VER = 7'd3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [8:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NPIN-1:0] pad_in, pad_oe, pad_out, pad_pull_en;
  logic            ctrl_clk_req, ctrl_sync_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pinbank_ctrl #(.NUM_PORTS(NP), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .ctrl_clk_req(ctrl_clk_req),
    .ctrl_sync_sel(ctrl_sync_sel)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ident();
    return (32'(NP) << 9) | (32'(VER) << 2);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check(pad_oe == '0, "R10 oe", 64'(pad_oe), 0);
    check(pad_out == '0, "R10 out", 64'(pad_out), 0);
    check(pad_pull_en == '1, "R10 pull", 64'(pad_pull_en), 64'({NPIN{1'b1}}));
    check(!ctrl_clk_req && !ctrl_sync_sel, "R10 ctrl bits", {ctrl_sync_sel, ctrl_clk_req}, 0);
    rd(9'h008, d); check(d == 0, "R10 dout", d, 0);
    rd(9'h00C, d); check(d == 0, "R10 mode", d, 0);
    rd(9'h010, d); check(d == 0, "R10 pdis", d, 0);
    rd(9'h000, d); check(d == ident(), "R8 ident at reset", d, ident());
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(9'h098, 32'hFFFF_FFA5); rd(9'h098, d); check(d == 32'hA5, "R1 port3 dout", d, 32'hA5);
    wr(9'h09C, 32'hABCD_1234); rd(9'h09C, d); check(d == 32'h1234, "R1 port3 mode", d, 32'h1234);
    wr(9'h130, 32'hFFFF_FFFF); rd(9'h130, d); check(d == 32'hFF, "R1 port6 pdis", d, 32'hFF);
    rd(9'h038, d); check(d == 0, "R1 port1 dout untouched", d, 0);
    wr(9'h09C, 0); wr(9'h098, 0); wr(9'h130, 0);
  endtask

  task automatic t_modes();
    logic [15:0] m = 16'h1BE4;
    wr(9'h06C, 32'(m));
    for (int pat = 0; pat < 2; pat++) begin
      logic [7:0] dv = (pat == 0) ? 8'h00 : 8'hFF;
      wr(9'h068, 32'(dv));
      for (int n = 0; n < 8; n++) begin
        logic [1:0] code = m[2*n +: 2];
        logic eo, eq;
        string tg;
        case (code)
          2'd0: begin eo = 0;       eq = 0;     tg = "R3"; end
          2'd1: begin eo = 1;       eq = dv[n]; tg = "R4"; end
          2'd2: begin eo = ~dv[n];  eq = 0;     tg = "R5"; end
          default: begin eo = dv[n]; eq = 1;    tg = "R6"; end
        endcase
        check(pad_oe[16+n] == eo, {tg, " R2 oe"}, pad_oe[16+n], eo);
        check(pad_out[16+n] == eq, {tg, " R2 out"}, pad_out[16+n], eq);
      end
    end
  endtask

  task automatic t_pull();
    wr(9'h040, 32'h0F);
    check(pad_pull_en[15:8] == 8'hF0, "R7 pull port1", pad_pull_en[15:8], 8'hF0);
    check(pad_pull_en[7:0] == 8'hFF, "R7 pull port0", pad_pull_en[7:0], 8'hFF);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(9'h000, 32'hFFFF_FFFF);
    rd(9'h000, d); check(d == (ident() | 3), "R8 ctrl readback", d, ident() | 3);
    check(ctrl_clk_req && ctrl_sync_sel, "R8 ctrl pins", {ctrl_sync_sel, ctrl_clk_req}, 3);
    wr(9'h000, 32'h1);
    check(ctrl_clk_req && !ctrl_sync_sel, "R8 ctrl bit0", {ctrl_sync_sel, ctrl_clk_req}, 1);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pad_in[39:32] = 8'h5A;
    rd(9'h0C4, d); check(d == 0, "R9 edge1 old", d, 0);
    rd(9'h0C4, d); check(d == 0, "R9 edge2 old", d, 0);
    rd(9'h0C4, d); check(d == 32'h5A, "R9 edge3 new", d, 32'h5A);
    wr(9'h0C4, 32'hFF);
    rd(9'h0C4, d); check(d == 32'h5A, "R9 write ignored", d, 32'h5A);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [NPIN-1:0] s_oe = pad_oe, s_out = pad_out, s_pu = pad_pull_en;
    wr(9'h158, 32'hFF); wr(9'h15C, 32'hFFFF); wr(9'h014, 32'hFF);
    wr(9'h030, 32'hFF); wr(9'h02C, 32'hFF);
    check(pad_oe == s_oe, "R11 oe unchanged", 64'(pad_oe), 64'(s_oe));
    check(pad_out == s_out, "R11 out unchanged", 64'(pad_out), 64'(s_out));
    check(pad_pull_en == s_pu, "R11 pull unchanged", 64'(pad_pull_en), 64'(s_pu));
    rd(9'h158, d); check(d == 0, "R11 beyond ports", d, 0);
    rd(9'h014, d); check(d == 0, "R11 unused offset", d, 0);
    rd(9'h030, d); check(d == 0, "R11 port1 slot 0", d, 0);
    rd(9'h1FF, d); check(d == 0, "R11 top address", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_modes();
    t_pull();
    t_ctrl();
    t_sync();
    t_unmapped();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule